// File: doc/BRIEF.md
# Multi-Mode Tick Timer

This block is a 16-bit counter that software drives through three registers on a plain read/write bus. The registers are a control word, the live count and a period limit. Four single-cycle tick inputs stand in for the clock sources. The control word picks one of them and sets a power-of-two prescaler of 1, 2, 4 or 8.

The prescaled tick steps the count in one of four modes:
- halted;
- rising to the period and wrapping to zero;
- free-running through the full 16-bit range;
- rising to the period and then falling back to zero.

A wrap event raises a pending flag. The interrupt output is that flag gated by an enable bit.

A one-shot clear command sits in the control word. It returns the count, the prescaler phase and the count direction to their starting values. It leaves the chosen divide ratio untouched. The command bit itself is never stored.

Top module: `tick_timer`

## Requirements
- R1: Control bits 9:8 select which tick input drives the timer: value k selects `tick_in[k]`. Ticks on the other three inputs have no effect on the count.
- R2: Control bits 7:6 set the prescale ratio: 00 gives /1, 01 gives /2, 10 gives /4 and 11 gives /8. The count steps once for each ratio-th selected tick.
- R3: Control bits 5:4 set the mode; mode 00 halts the timer. While halted, neither the count nor the prescaler phase moves, whatever the ticks do.
- R4: In mode 01 the count steps up on each prescaled tick. A step taken at or above the period value returns it to 0 and sets the flag (control bit 0).
- R5: In mode 10 the count steps up through 0xFFFF, wraps to 0 and sets the flag on that wrap. The period value has no effect in this mode.
- R6: In mode 11 the count rises to the period value, then falls by one per prescaled tick. It sets the flag on the step that reaches 0, then rises again.
- R7: Writing the control word with bit 2 set zeroes the count, restarts the prescaler phase and forces the direction to upward. The divide field takes the written value and is not reset by the command.
- R8: Control bit 2 always reads back as 0.
- R9: The output `irq` is high exactly when the flag (bit 0) and the enable (bit 1) are both 1. A control write loads the flag from bit 0, so writing 0 clears a pending flag.
- R10: All registers reset to 0. Control bits 15:10 and bit 3 ignore writes and read as 0. Address 3 reads as 0.
- R11: The address map is fixed: address 0 is the control word, 1 the count and 2 the period. A write to address 1 loads the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select: 0 control, 1 count, 2 period |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for the register at `addr`, combinational |
| tick_in | input | 4 | Tick-enable pulses, one per selectable source |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
The properties that relate count and flag to the advance pulse exclude any cycle that carries a bus write. This is because a write may legally override the count, the mode or the flag in that same cycle. The step-size property for mode 11 assumes the mode was already in force before the cycle it examines.

The directed stimulus always changes the mode through a full control write, and moves the tick inputs only on falling edges. Each scenario opens with a clear command, so every expected sequence starts from count 0 and direction upward.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int N_SRC     = 4;
    localparam int SRC_W     = 2;
    localparam int DIV_W     = 2;
    localparam int CTL_W     = 16;

    // control word bit positions; software decodes these
    localparam int B_SRC     = 8;
    localparam int B_DIV     = 6;
    localparam int B_MODE    = 4;
    localparam int B_CLR     = 2;
    localparam int B_IE      = 1;
    localparam int B_FLAG    = 0;

    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_CNT = 2'd1;
    localparam logic [1:0] A_PER = 2'd2;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_UP   = 2'b01,
        MODE_FREE = 2'b10,
        MODE_UPDN = 2'b11
    } mode_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        mode_e            mode;
        logic             ie;
        logic             flag;
    } ctl_t;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_sel,
    output logic             adv
);
    localparam int PCW = (1 << DIV_W) - 1;

    logic [PCW-1:0] ph_d, ph_q;
    logic [PCW-1:0] lim;

    // terminal phase is 2**div_sel - 1: the low div_sel bits set
    always_comb begin
        for (int i = 0; i < PCW; i++) begin
            lim[i] = (i < int'(div_sel));
        end
    end

    always_comb begin
        ph_d = ph_q;
        adv  = 1'b0;
        if (clr) begin
            ph_d = '0;
        end else if (run && tick) begin
            // >= so a ratio lowered mid-count still terminates at once
            if (ph_q >= lim) begin
                ph_d = '0;
                adv  = 1'b1;
            end else begin
                ph_d = ph_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

endmodule

// File: rtl/tt_count_core.sv
module tt_count_core
    import tick_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  mode_e         mode,
    input  logic [CW-1:0] period,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          wrap_evt
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
    } core_t;

    core_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        wrap_evt = 1'b0;
        if (mode != MODE_UPDN) s_d.down = 1'b0;
        if (clr) begin
            s_d.cnt  = '0;
            s_d.down = 1'b0;
        end else if (load) begin
            s_d.cnt = load_val;
        end else if (adv) begin
            unique case (mode)
                MODE_UP: begin
                    if (s_q.cnt >= period) begin
                        s_d.cnt  = '0;
                        wrap_evt = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                MODE_FREE: begin
                    s_d.cnt  = s_q.cnt + ONE;
                    wrap_evt = (s_q.cnt == '1);
                end
                MODE_UPDN: begin
                    if (s_q.down) begin
                        if (s_q.cnt <= ONE) begin
                            s_d.cnt  = '0;
                            s_d.down = 1'b0;
                            wrap_evt = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt - ONE;
                        end
                    end else if (s_q.cnt >= period) begin
                        // turn point; a period of 0 or 1 never leaves the up leg
                        if (s_q.cnt == ONE) begin
                            s_d.cnt  = '0;
                            wrap_evt = 1'b1;
                        end else if (s_q.cnt != '0) begin
                            s_d.cnt  = s_q.cnt - ONE;
                            s_d.down = 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CW-1:0]    wdata,
    output logic [CW-1:0]    rdata,
    input  logic [N_SRC-1:0] tick_in,
    output logic             irq
);
    typedef struct packed {
        ctl_t          ctl;
        logic [CW-1:0] period;
    } regs_t;

    regs_t r_d, r_q;

    logic          ctl_wr, cnt_wr, per_wr, clr_cmd;
    logic          adv_w, wrap_w, sel_tick;
    logic [CW-1:0] count_w;
    logic [1:0]    mode_w;
    logic [CW-1:0] per_w;
    logic          flag_w;
    logic [CTL_W-1:0] ctl_rd;

    assign ctl_wr   = wr_en && (addr == A_CTL);
    assign cnt_wr   = wr_en && (addr == A_CNT);
    assign per_wr   = wr_en && (addr == A_PER);
    assign clr_cmd  = ctl_wr && wdata[B_CLR];
    assign sel_tick = tick_in[r_q.ctl.src];

    tt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.ctl.mode != MODE_HALT),
        .tick    (sel_tick),
        .clr     (clr_cmd),
        .div_sel (r_q.ctl.div),
        .adv     (adv_w)
    );

    tt_count_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv_w),
        .mode     (r_q.ctl.mode),
        .period   (r_q.period),
        .clr      (clr_cmd),
        .load     (cnt_wr),
        .load_val (wdata),
        .count    (count_w),
        .wrap_evt (wrap_w)
    );

    always_comb begin
        r_d = r_q;
        if (ctl_wr) begin
            r_d.ctl.src  = wdata[B_SRC +: SRC_W];
            r_d.ctl.div  = wdata[B_DIV +: DIV_W];
            r_d.ctl.mode = mode_e'(wdata[B_MODE +: 2]);
            r_d.ctl.ie   = wdata[B_IE];
            r_d.ctl.flag = wdata[B_FLAG];
        end
        if (per_wr) r_d.period = wdata;
        // a wrap in the same cycle as a control write still leaves the flag set
        if (wrap_w) r_d.ctl.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctl_rd                   = '0;
        ctl_rd[B_SRC +: SRC_W]   = r_q.ctl.src;
        ctl_rd[B_DIV +: DIV_W]   = r_q.ctl.div;
        ctl_rd[B_MODE +: 2]      = r_q.ctl.mode;
        ctl_rd[B_IE]             = r_q.ctl.ie;
        ctl_rd[B_FLAG]           = r_q.ctl.flag;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTL:   rdata[CTL_W-1:0] = ctl_rd;
            A_CNT:   rdata = count_w;
            A_PER:   rdata = r_q.period;
            default: rdata = '0;
        endcase
    end

    assign irq    = r_q.ctl.flag & r_q.ctl.ie;
    assign mode_w = r_q.ctl.mode;
    assign per_w  = r_q.period;
    assign flag_w = r_q.ctl.flag;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          clr_cmd,
    input logic          ctl_sel,
    input logic [7:0]    rsvd,
    input logic [1:0]    mode,
    input logic          adv,
    input logic [CW-1:0] count,
    input logic [CW-1:0] period,
    input logic          flag
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    p_halt_noadv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !adv);

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !wr_en) |=> $stable(count));

    p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && adv && count >= period && !wr_en) |=> (count == '0 && flag));

    p_free_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && adv && count == '1 && !wr_en) |=> (count == '0 && flag));

    p_updn_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !wr_en) |=>
            (count == $past(count) || (count - $past(count)) == ONE
             || ($past(count) - count) == ONE));

    p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (count == '0));

    p_ctl_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel |-> (rsvd == 8'h00));

endmodule

bind tick_timer tick_timer_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .clr_cmd (clr_cmd),
    .ctl_sel (addr == 2'd0),
    .rsvd    ({rdata[15:10], rdata[3:2]}),
    .mode    (mode_w),
    .adv     (adv_w),
    .count   (count_w),
    .period  (per_w),
    .flag    (flag_w)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
    localparam int CW = 16;
    localparam logic [1:0] M_HALT = 2'b00, M_UP = 2'b01, M_FREE = 2'b10, M_UPDN = 2'b11;
    localparam logic [15:0] CLR = 16'h0004;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic [3:0]    tick_in = 4'h0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tick_timer #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_in(tick_in), .irq(irq)
    );

    function automatic logic [15:0] cw(input logic [1:0] src, input logic [1:0] dv,
                                       input logic [1:0] md, input logic ie, input logic fl);
        return {6'b0, src, dv, md, 2'b00, ie, fl};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic ticks(input int src, input int n);
        @(negedge clk);
        tick_in = 4'h0;
        tick_in[src] = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 4'h0;
    endtask

    task automatic t_reset;
        rd(2'd0, 16'h0000, "R10 ctl reset");
        rd(2'd1, 16'h0000, "R10 count reset");
        rd(2'd2, 16'h0000, "R10 period reset");
        check("R9 irq reset", 32'(irq), 0);
    endtask

    task automatic t_halt;
        wr(2'd2, 16'd50);
        wr(2'd0, cw(0, 2'b01, M_HALT, 0, 0) | CLR);
        ticks(0, 5);
        rd(2'd1, 16'd0, "R3 halt count holds");
        wr(2'd0, cw(0, 2'b01, M_UP, 0, 0));
        ticks(0, 1);
        rd(2'd1, 16'd0, "R3 prescaler phase held in halt");
        ticks(0, 1);
        rd(2'd1, 16'd1, "R3 resumes after halt");
    endtask

    task automatic t_up;
        wr(2'd2, 16'd3);
        wr(2'd0, cw(0, 0, M_UP, 0, 0) | CLR);
        ticks(0, 3);
        rd(2'd1, 16'd3, "R4 up reaches period");
        rd(2'd0, cw(0, 0, M_UP, 0, 0), "R4 no flag before wrap");
        ticks(0, 1);
        rd(2'd1, 16'd0, "R4 wrap to zero");
        rd(2'd0, cw(0, 0, M_UP, 0, 1), "R4 flag on wrap");
        check("R9 irq masked", 32'(irq), 0);
        wr(2'd0, cw(0, 0, M_HALT, 1, 1));
        check("R9 irq enabled", 32'(irq), 1);
        wr(2'd0, cw(0, 0, M_HALT, 1, 0));
        check("R9 flag cleared by write", 32'(irq), 0);
    endtask

    task automatic t_src;
        wr(2'd2, 16'd100);
        wr(2'd0, cw(2, 0, M_UP, 0, 0) | CLR);
        ticks(0, 3);
        ticks(1, 3);
        ticks(3, 3);
        rd(2'd1, 16'd0, "R1 unselected inputs ignored");
        ticks(2, 4);
        rd(2'd1, 16'd4, "R1 selected input counts");
    endtask

    task automatic t_div;
        wr(2'd2, 16'd100);
        wr(2'd0, cw(0, 2'b10, M_UP, 0, 0) | CLR);
        ticks(0, 3);
        rd(2'd1, 16'd0, "R2 /4 before fourth tick");
        ticks(0, 1);
        rd(2'd1, 16'd1, "R2 /4 first step");
        ticks(0, 8);
        rd(2'd1, 16'd3, "R2 /4 steady");
        wr(2'd0, cw(0, 2'b11, M_UP, 0, 0) | CLR);
        ticks(0, 16);
        rd(2'd1, 16'd2, "R2 /8");
        wr(2'd0, cw(0, 2'b01, M_UP, 0, 0) | CLR);
        ticks(0, 6);
        rd(2'd1, 16'd3, "R2 /2");
    endtask

    task automatic t_clear;
        wr(2'd2, 16'd100);
        wr(2'd0, cw(0, 2'b11, M_UP, 0, 0) | CLR);
        ticks(0, 13);
        rd(2'd1, 16'd1, "R7 setup count");
        wr(2'd0, cw(0, 2'b11, M_UP, 0, 0) | CLR);
        rd(2'd1, 16'd0, "R7 clear zeroes count");
        rd(2'd0, cw(0, 2'b11, M_UP, 0, 0), "R8 clear bit reads 0, divide kept");
        ticks(0, 7);
        rd(2'd1, 16'd0, "R7 prescaler phase restarted");
        ticks(0, 1);
        rd(2'd1, 16'd1, "R7 first step after clear");
        wr(2'd2, 16'd2);
        wr(2'd0, cw(0, 0, M_UPDN, 0, 0) | CLR);
        ticks(0, 3);
        rd(2'd1, 16'd1, "R7 setup falling leg");
        wr(2'd0, cw(0, 0, M_UPDN, 0, 0) | CLR);
        ticks(0, 1);
        rd(2'd1, 16'd1, "R7 direction forced upward");
    endtask

    task automatic t_free;
        wr(2'd2, 16'd5);
        wr(2'd0, cw(0, 0, M_FREE, 0, 0) | CLR);
        wr(2'd1, 16'd4);
        rd(2'd1, 16'd4, "R11 count load");
        ticks(0, 3);
        rd(2'd1, 16'd7, "R5 period ignored");
        wr(2'd1, 16'hFFFE);
        ticks(0, 1);
        rd(2'd1, 16'hFFFF, "R5 reaches all ones");
        rd(2'd0, cw(0, 0, M_FREE, 0, 0), "R5 no flag at all ones");
        ticks(0, 1);
        rd(2'd1, 16'h0000, "R5 wraps");
        rd(2'd0, cw(0, 0, M_FREE, 0, 1), "R5 flag on wrap");
    endtask

    task automatic t_updn;
        logic [15:0] seq [7] = '{16'd1, 16'd2, 16'd3, 16'd2, 16'd1, 16'd0, 16'd1};
        wr(2'd2, 16'd3);
        wr(2'd0, cw(0, 0, M_UPDN, 1, 0) | CLR);
        for (int i = 0; i < 7; i++) begin
            ticks(0, 1);
            rd(2'd1, seq[i], $sformatf("R6 step %0d", i));
            if (i < 5) check($sformatf("R6 no flag at step %0d", i), 32'(irq), 0);
            if (i == 5) check("R6 flag at zero", 32'(irq), 1);
        end
    endtask

    task automatic t_rsvd;
        wr(2'd0, 16'hFC08 | cw(1, 1, M_HALT, 0, 0));
        rd(2'd0, cw(1, 1, M_HALT, 0, 0), "R10 reserved bits read 0");
        rd(2'd3, 16'h0000, "R10 unused address reads 0");
        wr(2'd2, 16'h1234);
        rd(2'd2, 16'h1234, "R11 period register");
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halt();
        t_up();
        t_src();
        t_div();
        t_clear();
        t_free();
        t_updn();
        t_rsvd();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule